// File: doc/BRIEF.md
# Link Pulse Generator and Integrity Monitor

This block is the timing core of one 10 Mb/s twisted-pair port. It does two jobs. On the transmit side it asks the line driver for a short link test pulse at a fixed interval. It does this only while the MAC is not sending. Every cycle of transmit enable aborts a pulse in progress and restarts the interval, so the first pulse after a frame comes one full interval after the line goes quiet.

On the receive side it watches for link pulses and packet carrier from the far end. If neither arrives for the loss timeout, it declares the link down. While the link is down, the port's transmit, receive and collision paths are held off rather than only flagged.

The link comes back after a run of received link pulses, each one close enough in time to the one before it. Carrier does not count toward recovery. With a 20 MHz clock the defaults give a 100 ns pulse, a 16 ms interval and a 100 ms loss timeout.

Top module: `link_integrity_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `lp_req`, `link_ok`, `tx_gated`, `rx_gated` and `col_gated` are 0 and `link_lost` is 1; the link starts down.
- R2: Each link pulse holds `lp_req` high for exactly PULSE_CYC consecutive cycles, unless transmit enable cuts it short.
- R3: With `tx_en` low, `lp_req` rises on the PERIOD_CYC-th clock edge after reset or after the last edge that sampled `tx_en` high, and then every PERIOD_CYC edges.
- R4: An edge that samples `tx_en` high drives `lp_req` low, ends any pulse in progress and restarts the interval of R3.
- R5: While the link is up, `link_ok` falls on the LOSS_CYC-th consecutive edge that samples both `rx_pulse` and `rx_carrier` low.
- R6: While the link is up, an edge that samples `rx_carrier` high counts as link activity just as `rx_pulse` does, and restarts the loss count.
- R7: While the link is down, only `rx_pulse` counts toward recovery. `link_ok` rises on the edge that samples the RESTORE_PULSES-th pulse of a run in which each pulse edge comes at most LOSS_CYC edges after the previous one. `rx_carrier` alone never raises it.
- R8: `tx_gated`, `rx_gated` and `col_gated` register `tx_en`, `rx_carrier` and (`tx_en` AND `rx_carrier`) one cycle later, ANDed with the `link_ok` value present at that edge; while the link is down they stay 0.
- R9: `link_lost` is always the inverse of `link_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (20 MHz for the default timings) |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | MAC is sending data |
| rx_pulse | input | 1 | One-cycle strobe per valid link pulse received |
| rx_carrier | input | 1 | Valid packet carrier is present on the receive pair |
| lp_req | output | 1 | Request to the driver to send a link test pulse |
| link_ok | output | 1 | Link integrity is good |
| link_lost | output | 1 | Link integrity has failed (high when down) |
| tx_gated | output | 1 | Transmit function enable, gated by link state |
| rx_gated | output | 1 | Receive carrier, gated by link state |
| col_gated | output | 1 | Collision indication, gated by link state |

## Verification
The bench drives the loss timer to exactly one cycle short of the timeout and then to the timeout itself. A counter that is off by one would either drop the link early or keep it one cycle too long.

It checks recovery with two pulse gaps. One gap is one cycle longer than the window and must not restore the link; the other sits exactly at the window and must. A design that compared the gap with the wrong bound fails one of the two. It also applies carrier alone while the link is down, which a design that counted carrier toward recovery would accept.

It raises transmit enable in the middle of a link pulse and then measures the delay to the next pulse. A design that did not truncate the pulse or restart the interval would show the pulse too long or the next one too early.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } lnk_state_e;
endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
  parameter int PERIOD_CYC = 320000,
  parameter int PULSE_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  output logic lp_req
);
  localparam int CW  = $clog2(PERIOD_CYC);
  localparam int PCW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0]  idle_cnt;
  logic [PCW-1:0] width_cnt;

  // Interval counter restarts on every transmit cycle; pulse width counted down.
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt  <= '0;
      width_cnt <= '0;
      lp_req    <= 1'b0;
    end else if (tx_en) begin
      idle_cnt  <= '0;
      width_cnt <= '0;
      lp_req    <= 1'b0;
    end else if (idle_cnt == CW'(PERIOD_CYC - 1)) begin
      idle_cnt  <= '0;
      lp_req    <= 1'b1;
      width_cnt <= PCW'(PULSE_CYC - 1);
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
      if (lp_req) begin
        if (width_cnt == '0) lp_req <= 1'b0;
        else                 width_cnt <= width_cnt - 1'b1;
      end
    end
  end

  AST_TX_BLOCKS_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> !lp_req);  // R4

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    idle_cnt < CW'(PERIOD_CYC));  // R3

  generate
    if (PULSE_CYC > 1) begin : g_wide
      AST_PULSE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(lp_req) && !tx_en) |=> lp_req);  // R2
    end
  endgenerate
endmodule

// File: rtl/lnk_monitor.sv
module lnk_monitor
  import lnk_pkg::*;
#(
  parameter int LOSS_CYC       = 2000000,
  parameter int RESTORE_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pulse,
  input  logic rx_carrier,
  output logic link_ok
);
  localparam int QW = $clog2(LOSS_CYC);
  localparam int SW = $clog2(RESTORE_PULSES + 1);

  lnk_state_e     state;
  logic [QW-1:0]  quiet;
  logic [SW-1:0]  streak;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= LNK_DOWN;
      quiet  <= '0;
      streak <= '0;
    end else if (state == LNK_UP) begin
      if (rx_pulse || rx_carrier) begin
        quiet <= '0;
      end else if (quiet == QW'(LOSS_CYC - 1)) begin
        state  <= LNK_DOWN;
        quiet  <= '0;
        streak <= '0;
      end else begin
        quiet <= quiet + 1'b1;
      end
    end else begin
      if (rx_pulse) begin
        quiet <= '0;
        if (streak == SW'(RESTORE_PULSES - 1)) begin
          state  <= LNK_UP;
          streak <= '0;
        end else begin
          streak <= streak + 1'b1;
        end
      end else if (quiet == QW'(LOSS_CYC - 1)) begin
        quiet  <= '0;
        streak <= '0;
      end else begin
        quiet <= quiet + 1'b1;
      end
    end
  end

  assign link_ok = (state == LNK_UP);

  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (rst)
    quiet < QW'(LOSS_CYC));  // R5

  AST_ACTIVITY_HOLDS_LINK: assert property (@(posedge clk) disable iff (rst)
    (link_ok && (rx_pulse || rx_carrier)) |=> link_ok);  // R6

  AST_NO_RESTORE_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!link_ok && !rx_pulse) |=> !link_ok);  // R7
endmodule

// File: rtl/lnk_port_gate.sv
module lnk_port_gate (
  input  logic clk,
  input  logic rst,
  input  logic link_ok,
  input  logic tx_en,
  input  logic rx_carrier,
  output logic tx_gated,
  output logic rx_gated,
  output logic col_gated
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_gated  <= 1'b0;
      rx_gated  <= 1'b0;
      col_gated <= 1'b0;
    end else begin
      tx_gated  <= tx_en & link_ok;
      rx_gated  <= rx_carrier & link_ok;
      col_gated <= tx_en & rx_carrier & link_ok;
    end
  end

  AST_GATE_OFF_WHEN_DOWN: assert property (@(posedge clk) disable iff (rst)
    !link_ok |=> !(tx_gated || rx_gated || col_gated));  // R8

  AST_COL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    col_gated |-> (tx_gated && rx_gated));  // R8
endmodule

// File: rtl/link_integrity_unit.sv
module link_integrity_unit #(
  parameter int PERIOD_CYC     = 320000,
  parameter int PULSE_CYC      = 2,
  parameter int LOSS_CYC       = 2000000,
  parameter int RESTORE_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic rx_pulse,
  input  logic rx_carrier,
  output logic lp_req,
  output logic link_ok,
  output logic link_lost,
  output logic tx_gated,
  output logic rx_gated,
  output logic col_gated
);
  lnk_pulse_gen #(
    .PERIOD_CYC(PERIOD_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_gen (
    .clk   (clk),
    .rst   (rst),
    .tx_en (tx_en),
    .lp_req(lp_req)
  );

  lnk_monitor #(
    .LOSS_CYC      (LOSS_CYC),
    .RESTORE_PULSES(RESTORE_PULSES)
  ) u_mon (
    .clk       (clk),
    .rst       (rst),
    .rx_pulse  (rx_pulse),
    .rx_carrier(rx_carrier),
    .link_ok   (link_ok)
  );

  lnk_port_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .link_ok   (link_ok),
    .tx_en     (tx_en),
    .rx_carrier(rx_carrier),
    .tx_gated  (tx_gated),
    .rx_gated  (rx_gated),
    .col_gated (col_gated)
  );

  assign link_lost = ~link_ok;

  AST_LINK_RISE_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(link_ok) |-> $past(rx_pulse));  // R7
endmodule

// File: tb/tb_link_integrity_unit.sv
module tb_link_integrity_unit;
  localparam int CLK_PERIOD = 10;
  localparam int P_PER  = 40;
  localparam int P_PUL  = 2;
  localparam int P_LOSS = 100;
  localparam int P_RST  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, rx_pulse = 1'b0, rx_carrier = 1'b0;
  logic lp_req, link_ok, link_lost, tx_gated, rx_gated, col_gated;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int m_idle, m_prem, m_quiet, m_streak, m_sincep;
  bit m_ok, e_tx, e_rx, e_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_integrity_unit #(
    .PERIOD_CYC(P_PER), .PULSE_CYC(P_PUL),
    .LOSS_CYC(P_LOSS), .RESTORE_PULSES(P_RST)
  ) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_pulse(rx_pulse),
    .rx_carrier(rx_carrier), .lp_req(lp_req), .link_ok(link_ok),
    .link_lost(link_lost), .tx_gated(tx_gated), .rx_gated(rx_gated),
    .col_gated(col_gated)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idle = 0; m_prem = 0; m_quiet = 0; m_streak = 0; m_sincep = 0;
    m_ok = 0; e_tx = 0; e_rx = 0; e_col = 0;
  endtask

  task automatic model_step(input bit t, input bit p, input bit c);
    bit old_ok;
    old_ok = m_ok;
    e_tx  = t && old_ok;
    e_rx  = c && old_ok;
    e_col = t && c && old_ok;
    if (t) begin
      m_idle = 0; m_prem = 0;
    end else begin
      m_idle++;
      if (m_idle == P_PER) begin m_idle = 0; m_prem = P_PUL; end
      else if (m_prem > 0) m_prem--;
    end
    if (old_ok) begin
      if (p || c) m_quiet = 0;
      else begin
        m_quiet++;
        if (m_quiet == P_LOSS) begin m_ok = 0; m_streak = 0; end
      end
    end else if (p) begin
      m_streak = (m_streak > 0 && m_sincep < P_LOSS) ? m_streak + 1 : 1;
      if (m_streak >= P_RST) begin m_ok = 1; m_streak = 0; m_quiet = 0; end
    end
    m_sincep = p ? 0 : m_sincep + 1;
  endtask

  task automatic compare_all();
    check("R3 lp_req vs model", lp_req, (m_prem > 0) ? 1 : 0);
    check("R5 link_ok vs model", link_ok, m_ok);
    check("R9 link_lost", link_lost, !m_ok);
    check("R8 tx_gated vs model", tx_gated, e_tx);
    check("R8 rx_gated vs model", rx_gated, e_rx);
    check("R8 col_gated vs model", col_gated, e_col);
  endtask

  task automatic cyc(input bit t, input bit p, input bit c);
    tx_en = t; rx_pulse = p; rx_carrier = c;
    @(posedge clk);
    model_step(t, p, c);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check("R1 lp_req in reset", lp_req, 0);
    check("R1 link_ok in reset", link_ok, 0);
    check("R1 link_lost in reset", link_lost, 1);
    check("R1 gated in reset", tx_gated | rx_gated | col_gated, 0);
    rst = 1'b0;

    // R3 / R2: first pulse timing and width, link down
    repeat (P_PER - 1) cyc(0, 0, 0);
    check("R3 no pulse before interval", lp_req, 0);
    cyc(0, 0, 0);
    check("R3 pulse at interval", lp_req, 1);
    cyc(0, 0, 0);
    check("R2 pulse second cycle", lp_req, 1);
    cyc(0, 0, 0);
    check("R2 pulse ends after width", lp_req, 0);
    repeat (60) cyc(0, 0, 0);

    // R7: carrier alone does not restore
    repeat (20) cyc(0, 0, 1);
    check("R7 carrier no restore", link_ok, 0);
    check("R8 rx gated off while down", rx_gated, 0);
    // R7: two pulses 50 apart restore
    cyc(0, 1, 0);
    check("R7 one pulse not enough", link_ok, 0);
    repeat (49) cyc(0, 0, 0);
    cyc(0, 1, 0);
    check("R7 restored after two pulses", link_ok, 1);

    // R6: carrier keeps link up
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 1);
      repeat (P_LOSS - 11) cyc(0, 0, 0);
    end
    check("R6 carrier keeps link", link_ok, 1);

    // R8: transmit with carrier gives collision
    repeat (10) cyc(1, 0, 1);
    check("R8 tx_gated passes", tx_gated, 1);
    check("R8 col_gated passes", col_gated, 1);

    // R4: raise tx_en during a pulse
    for (int k = 0; k < 2 * P_PER && lp_req == 1'b0; k++) cyc(0, 0, 1);
    check("R4 pulse found", lp_req, 1);
    cyc(1, 0, 1);
    check("R4 tx cuts pulse", lp_req, 0);
    repeat (P_PER - 1) cyc(0, 0, 1);
    check("R4 interval restarted", lp_req, 0);
    cyc(0, 0, 1);
    check("R4 pulse after restart", lp_req, 1);

    // R5: loss timeout exact
    repeat (P_LOSS - 1) cyc(0, 0, 0);
    check("R5 still up one short", link_ok, 1);
    cyc(0, 0, 0);
    check("R5 down at timeout", link_ok, 0);
    check("R9 lost high", link_lost, 1);
    cyc(1, 0, 1);
    check("R8 tx gated off when down", tx_gated, 0);

    // R7: gap one over window fails, gap at window restores
    cyc(0, 1, 0);
    repeat (P_LOSS) cyc(0, 0, 0);
    cyc(0, 1, 0);
    check("R7 gap too long no restore", link_ok, 0);
    repeat (P_LOSS - 1) cyc(0, 0, 0);
    cyc(0, 1, 0);
    check("R7 gap at window restores", link_ok, 1);
    repeat (5) cyc(0, 0, 1);

    finish_run();
  end
endmodule